// File: doc/BRIEF.md
# Message-Triggered Interrupt Register Unit

This unit holds a small bank of 32-bit message registers. Each one drives its own interrupt source. When one agent writes a message register, the unit raises an interrupt to the agent that owns that source. The raise happens only if that source's enable bit is set at the moment of the write. The receiver reads the message, then retires the interrupt by writing a one to the matching status bit.

Two gating points act differently. The enable bit is checked only when the message is written. A message written while its source is disabled leaves no trace, and enabling the source later does not bring it back. The mask bit acts on the output only. A pending interrupt is held while its source is masked, and it drives its request line as soon as the mask is lifted.

Software sets every enable bit once after reset and then leaves them alone. Per-source masking is done through the mask register.

Top module: `msg_irq_unit`

## Requirements
- R1: After reset, all message registers, the enable register, the status register and the mask register read as zero, and every `irq_o` line is low.
- R2: A write to message register n (byte address 4·n, n = 0..3) stores the full 32-bit word. A read returns the last value written. Reading a message register does not change the status register.
- R3: A write to message register n while enable bit n is 1 makes status bit n read as 1. If mask bit n is 0, it also drives `irq_o[n]` high from the next cycle.
- R4: A write to message register n while enable bit n is 0 leaves status bit n and `irq_o[n]` unchanged. Setting enable bit n afterwards does not raise interrupt n.
- R5: The enable register (address 0x10) keeps enable bit n in data bit n. The status register (0x14) shows pending bit n in data bit n. The mask register (0x18) keeps mask bit n in data bit n. Data bits 31:4 of these three registers read as zero.
- R6: Writing the status register clears pending bit n for every data bit n written as 1. Bits written as 0 are left unchanged.
- R7: While mask bit n is 1, `irq_o[n]` is low but status bit n keeps its pending value. Clearing mask bit n drives `irq_o[n]` high if status bit n is 1.
- R8: Clearing enable bit n does not clear an interrupt that is already pending on source n.
- R9: A read from an unmapped word address returns zero. A write to an unmapped word address changes no register.
- R10: `irq_o[n]` is high exactly when status bit n is 1 and mask bit n is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 6 | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 4 | Interrupt request line for each message source |

## Verification
The assertions are checked on every cycle. They cover four rules: an enabled message write always leaves its source pending, a disabled write never creates a pending source, a status clear without a new write retires the source, and a pending source stays pending until it is cleared. A further assertion confirms that a message register holds its value when it is not written. The bench scenarios show behaviour that only a sequence can reveal: a lost write that stays lost after enable, deferral and release through the mask, the read layout of the control registers, and the effect of a reset in the middle of activity.

// File: rtl/msg_irq_pkg.sv
package msg_irq_pkg;

  // Which register a bus address points at
  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_MSG  = 3'd1,
    SEL_EN   = 3'd2,
    SEL_ST   = 3'd3,
    SEL_MK   = 3'd4
  } reg_sel_e;

endpackage

// File: rtl/msg_irq_decode.sv
module msg_irq_decode
  import msg_irq_pkg::*;
#(
  parameter int NUM_MSG = 4,
  parameter int ADDR_W  = 6
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       wr,
  output reg_sel_e                   sel,
  output logic [$clog2(NUM_MSG)-1:0] msg_idx,
  output logic [NUM_MSG-1:0]         msg_we,
  output logic                       en_we,
  output logic                       st_we,
  output logic                       mk_we
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int IDX_W  = $clog2(NUM_MSG);
  localparam int EN_WORD = NUM_MSG;
  localparam int ST_WORD = NUM_MSG + 1;
  localparam int MK_WORD = NUM_MSG + 2;

  logic [WORD_W-1:0] word;

  assign word    = addr[ADDR_W-1:2];
  assign msg_idx = word[IDX_W-1:0];

  always_comb begin
    if (32'(word) < NUM_MSG)        sel = SEL_MSG;
    else if (32'(word) == EN_WORD)  sel = SEL_EN;
    else if (32'(word) == ST_WORD)  sel = SEL_ST;
    else if (32'(word) == MK_WORD)  sel = SEL_MK;
    else                            sel = SEL_NONE;
  end

  assign en_we = wr && (sel == SEL_EN);
  assign st_we = wr && (sel == SEL_ST);
  assign mk_we = wr && (sel == SEL_MK);

  for (genvar i = 0; i < NUM_MSG; i++) begin : g_we
    assign msg_we[i] = wr && (sel == SEL_MSG) && (msg_idx == IDX_W'(i));
  end

endmodule

// File: rtl/msg_irq_store.sv
module msg_irq_store #(
  parameter int NUM_MSG = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MSG-1:0] msg_we,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  msg_q [NUM_MSG]
);

  for (genvar i = 0; i < NUM_MSG; i++) begin : g_msg
    logic [DATA_W-1:0] msg_d;

    always_comb begin
      msg_d = msg_q[i];
      if (msg_we[i]) msg_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          msg_q[i] <= '0;
      else if (msg_we[i])  msg_q[i] <= msg_d;
    end

    // R2: a message register only changes when it is written
    a_r2_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !msg_we[i] |=> $stable(msg_q[i]));
  end

endmodule

// File: rtl/msg_irq_ctrl.sv
module msg_irq_ctrl #(
  parameter int NUM_MSG = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MSG-1:0] msg_we,
  input  logic               en_we,
  input  logic               st_we,
  input  logic               mk_we,
  input  logic [NUM_MSG-1:0] wbits,
  output logic [NUM_MSG-1:0] en_q,
  output logic [NUM_MSG-1:0] pend_q,
  output logic [NUM_MSG-1:0] mask_q,
  output logic [NUM_MSG-1:0] irq
);
  logic [NUM_MSG-1:0] en_d, mask_d, pend_d, clr;
  logic [NUM_MSG-1:0] raise;

  assign clr   = st_we ? wbits : '0;
  assign raise = msg_we & en_q;   // enable sampled at write time

  always_comb begin
    en_d   = en_we ? wbits : en_q;
    mask_d = mk_we ? wbits : mask_q;
    // A new enabled write wins over a clear in the same cycle
    pend_d = raise | (pend_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (en_we) en_q   <= en_d;
      if (mk_we) mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  assign irq = pend_q & ~mask_q;

  for (genvar i = 0; i < NUM_MSG; i++) begin : g_chk
    // R3
    a_r3_enabled_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
      msg_we[i] && en_q[i] |=> pend_q[i]);
    // R4
    a_r4_disabled_write_lost: assert property (@(posedge clk) disable iff (!rst_n)
      msg_we[i] && !en_q[i] && !pend_q[i] |=> !pend_q[i]);
    // R6
    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      st_we && wbits[i] && !msg_we[i] |=> !pend_q[i]);
    // R8
    a_r8_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[i] && !(st_we && wbits[i]) |=> pend_q[i]);
  end

endmodule

// File: rtl/msg_irq_unit.sv
module msg_irq_unit
  import msg_irq_pkg::*;
#(
  parameter int NUM_MSG = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_MSG-1:0] irq_o
);
  localparam int IDX_W = $clog2(NUM_MSG);

  logic [1:0]         rst_sync_q;
  logic               rst_n_int;
  reg_sel_e           sel;
  logic [IDX_W-1:0]   msg_idx;
  logic [NUM_MSG-1:0] msg_we;
  logic               en_we, st_we, mk_we;
  logic [DATA_W-1:0]  msg_q [NUM_MSG];
  logic [NUM_MSG-1:0] en_q, pend_q, mask_q;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  msg_irq_decode #(.NUM_MSG(NUM_MSG), .ADDR_W(ADDR_W)) u_decode (
    .addr(bus_addr), .wr(bus_wr), .sel(sel), .msg_idx(msg_idx),
    .msg_we(msg_we), .en_we(en_we), .st_we(st_we), .mk_we(mk_we)
  );

  msg_irq_store #(.NUM_MSG(NUM_MSG), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n_int), .msg_we(msg_we), .wdata(bus_wdata),
    .msg_q(msg_q)
  );

  msg_irq_ctrl #(.NUM_MSG(NUM_MSG)) u_ctrl (
    .clk(clk), .rst_n(rst_n_int), .msg_we(msg_we), .en_we(en_we),
    .st_we(st_we), .mk_we(mk_we), .wbits(bus_wdata[NUM_MSG-1:0]),
    .en_q(en_q), .pend_q(pend_q), .mask_q(mask_q), .irq(irq_o)
  );

  always_comb begin
    case (sel)
      SEL_MSG: bus_rdata = msg_q[msg_idx];
      SEL_EN:  bus_rdata = DATA_W'(en_q);
      SEL_ST:  bus_rdata = DATA_W'(pend_q);
      SEL_MK:  bus_rdata = DATA_W'(mask_q);
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: tb/msg_irq_unit_bench.sv
module msg_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_o;

  int checks = 0;
  int errors = 0;

  always #5ns clk = ~clk;

  msg_irq_unit u_msg_irq_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  localparam logic [5:0] A_M0 = 6'h00, A_M1 = 6'h04, A_M2 = 6'h08, A_M3 = 6'h0C;
  localparam logic [5:0] A_EN = 6'h10, A_ST = 6'h14, A_MK = 6'h18, A_XX = 6'h1C;

  // {write, addr, data (write data or expected read), expected irq, req}
  localparam int NV = 31;
  localparam logic [46:0] VEC [NV] = '{
    {1'b0, A_EN, 32'h0,          4'h0, 4'd1},   // R1
    {1'b0, A_ST, 32'h0,          4'h0, 4'd1},   // R1
    {1'b1, A_M0, 32'hA5A5_0001,  4'h0, 4'd4},   // R4 disabled write
    {1'b0, A_ST, 32'h0,          4'h0, 4'd4},
    {1'b1, A_EN, 32'hFFFF_FFFF,  4'h0, 4'd5},
    {1'b0, A_EN, 32'h0000_000F,  4'h0, 4'd5},   // R5 upper bits zero
    {1'b0, A_ST, 32'h0,          4'h0, 4'd4},   // R4 enabling does not revive
    {1'b0, A_M0, 32'hA5A5_0001,  4'h0, 4'd2},   // R2
    {1'b1, A_M2, 32'h1234_5678,  4'h0, 4'd3},
    {1'b0, A_ST, 32'h4,          4'h4, 4'd3},   // R3
    {1'b0, A_M2, 32'h1234_5678,  4'h4, 4'd2},
    {1'b0, A_ST, 32'h4,          4'h4, 4'd2},   // R2 read had no side effect
    {1'b1, A_ST, 32'hFFFF_FFFB,  4'h0, 4'd6},   // zeros leave bit 2
    {1'b0, A_ST, 32'h4,          4'h4, 4'd6},   // R6
    {1'b1, A_MK, 32'h4,          4'h0, 4'd7},
    {1'b0, A_ST, 32'h4,          4'h0, 4'd7},   // R7 masked, still pending
    {1'b1, A_M1, 32'hDEAD_BEEF,  4'h0, 4'd3},
    {1'b0, A_ST, 32'h6,          4'h2, 4'd10},  // R10
    {1'b1, A_MK, 32'h0,          4'h0, 4'd7},
    {1'b0, A_ST, 32'h6,          4'h6, 4'd7},   // R7 released
    {1'b1, A_EN, 32'h0,          4'h0, 4'd8},
    {1'b0, A_ST, 32'h6,          4'h6, 4'd8},   // R8
    {1'b1, A_M3, 32'h0000_0000,  4'h0, 4'd4},
    {1'b0, A_ST, 32'h6,          4'h6, 4'd4},
    {1'b1, A_ST, 32'h0000_0002,  4'h0, 4'd6},
    {1'b0, A_ST, 32'h4,          4'h4, 4'd6},   // R6 single clear
    {1'b0, A_MK, 32'h0,          4'h4, 4'd5},
    {1'b1, A_XX, 32'hFFFF_FFFF,  4'h0, 4'd9},
    {1'b0, A_XX, 32'h0,          4'h4, 4'd9},   // R9
    {1'b1, A_ST, 32'h0000_000F,  4'h0, 4'd6},
    {1'b0, A_ST, 32'h0,          4'h0, 4'd6}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1ns;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2ms;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    do_reset();

    // R1 reset state of every register and line
    for (int i = 0; i < 7; i++) begin
      bus_read(6'(i * 4), rd);
      check($sformatf("R1 reg %0d", i), rd, 32'h0);
    end
    check("R1 irq", 32'(irq_o), 32'h0);

    for (int v = 0; v < NV; v++) begin
      logic [46:0] e;
      e = VEC[v];
      if (e[46]) begin
        bus_write(e[45:40], e[39:8]);
      end else begin
        bus_read(e[45:40], rd);
        check($sformatf("R%0d vec %0d rdata", e[3:0], v), rd, e[39:8]);
        check($sformatf("R10 vec %0d irq", v), 32'(irq_o), 32'(e[7:4]));
      end
    end

    // R3 irq rises the cycle after the enabled write
    bus_write(A_EN, 32'hF);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_M3; bus_wdata = 32'h0BAD_F00D;
    #1ns;
    check("R3 irq before edge", 32'(irq_o), 32'h0);
    @(negedge clk);
    bus_wr = 1'b0;
    check("R3 irq after edge", 32'(irq_o), 32'h8);

    // R1 reset in the middle of activity
    bus_write(A_MK, 32'h1);
    do_reset();
    bus_read(A_M3, rd);
    check("R1 msg after mid reset", rd, 32'h0);
    bus_read(A_ST, rd);
    check("R1 status after mid reset", rd, 32'h0);
    bus_read(A_MK, rd);
    check("R1 mask after mid reset", rd, 32'h0);
    check("R1 irq after mid reset", 32'(irq_o), 32'h0);

    // R4 disabled after reset: write lost, enable afterwards still quiet
    bus_write(A_M1, 32'h1);
    bus_write(A_EN, 32'hF);
    bus_read(A_ST, rd);
    check("R4 lost after reset", rd, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule